// File: doc/BRIEF.md
# Cyclic Wake-Up Contact Sensor

This block watches a small group of wake-up contact inputs on behalf of a power-management controller and decides when a contact has truly changed state. In static mode every input is watched all the time, and a new level is accepted only after it has held for a full debounce interval. In cyclic mode the block powers the external contacts only for short bursts. It drives a contact-supply enable once per period, waits a settle delay, and then samples each input through a short stability window. The result is compared with the sample taken in the previous period.

The accepted levels are held in a status vector that the host can read. Any accepted change on an enabled input produces a one-cycle wake request and sets a sticky wake flag, which stays set until the host acknowledges it. All timing is counted in base ticks taken from a clock prescaler, and every duration is a parameter. The configuration arrives on plain parallel inputs. The host is expected to change the timer settings only while the block is in static mode.

The sequencer has five states. IDLE is static mode. SETTLE turns the supply on and counts the settle delay. WINDOW keeps the supply on and filters the samples. HOLD keeps the supply on until the on-time ends. REST keeps the supply off until the period ends. The transitions are:
- IDLE→SETTLE when cyclic mode is selected.
- SETTLE→WINDOW when the delay expires.
- WINDOW→HOLD at the end of the window, which is the evaluation point.
- HOLD→REST when the on-time expires.
- REST→SETTLE when the period expires.
- Any state→IDLE when cyclic mode is deselected.

Top module: `cws_wake_sensor`

## Requirements
- R1: While reset is asserted and after it is released, the block holds the following values until an input is accepted:
  - `in_status` is all zero.
  - `supply_on` is low.
  - `wake_pulse` is low.
  - `wake_flag` is low.
- R2: In static mode (`mode_cyclic`=0), an input whose level differs from its status bit for STATIC_FILT_TICKS consecutive ticks updates that status bit on the last of those ticks. A difference that lasts fewer ticks leaves the status unchanged and raises no wake.
- R3: Both a rising and a falling accepted change raise a wake request.
- R4: Bit i of `wake_en` set to 0 suppresses wakes from input i. The status bit still follows the accepted level in both modes.
- R5: In cyclic mode, `supply_on` is high for the on-time and repeats once per period. The values are selected as follows:
  - `timer_sel`=0: the period is (`period_code`+1)·T1_STEP_TICKS, and the on-time is ON_T1_LONG or ON_T1_SHORT as selected by `on_long`=1 or 0.
  - `timer_sel`=1: the period is T2_PERIOD_TICKS, and the on-time is ON_T2_LONG or ON_T2_SHORT.
- R6: In cyclic mode, the inputs are sampled only from DLY ticks after the rise of `supply_on`, where DLY is DLY_LONG_TICKS when `delay_long`=1 and DLY_SHORT_TICKS otherwise. Sampling lasts for a CYC_FILT_TICKS window. `in_status` changes only at the end of that window.
- R7: At the end of a cyclic window, a stable sample that differs from the stored status updates the status and raises a wake if the input is enabled. A sample equal to the stored status raises no wake.
- R8: If an input changes level anywhere inside the cyclic window, its status is kept and no wake is raised for it in that period.
- R9: The first evaluation after entering cyclic mode stores the samples as the reference and raises no wake.
- R10: `wake_pulse` lasts one cycle per accepted change and sets `wake_flag` in the same cycle. `wake_ack` clears `wake_flag` on the next edge. When a new wake and an acknowledge coincide, the flag stays set.
- R11: In static mode `supply_on` is low from the cycle after `mode_cyclic` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_cyclic | input | 1 | 0 = static monitoring, 1 = cyclic sampling |
| timer_sel | input | 1 | 0 = long programmable period, 1 = short fixed period |
| period_code | input | 3 | Long-period multiplier minus one |
| on_long | input | 1 | Selects the longer supply on-time of the chosen timer |
| delay_long | input | 1 | Selects the longer settle delay |
| wake_en | input | N_IN | Per-input wake enable |
| wake_in | input | N_IN | Contact levels, synchronous to clk |
| wake_ack | input | 1 | Clears the sticky wake flag |
| supply_on | output | 1 | Contact-supply enable |
| in_status | output | N_IN | Accepted input levels |
| wake_pulse | output | 1 | One-cycle wake request |
| wake_flag | output | 1 | Sticky wake indication |

## Verification
A freshly accepted change and a host acknowledge can land on the same clock edge. Both act on the sticky flag at once. The bench provokes this in static mode by raising `wake_ack` on the cycle before the debounce interval of a pending change completes. It then requires the flag to be high together with the pulse, and to be cleared only by a later lone acknowledge. A second overlap happens when an input changes inside the cyclic sampling window while the evaluation point falls due. The bench places that change a known number of ticks after the supply rises. It expects the old status and no wake in that period, and then the new level with a wake one period later.

// File: rtl/cws_pkg.sv
package cws_pkg;

    typedef enum logic [2:0] {
        CS_IDLE,
        CS_SETTLE,
        CS_WINDOW,
        CS_HOLD,
        CS_REST
    } cyc_state_t;

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/cws_tick_gen.sv
module cws_tick_gen #(
    parameter int unsigned DIV = 200
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int unsigned DW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [DW-1:0] cnt_q;

    assign tick = (cnt_q == DW'(DIV - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + DW'(1);
        end
    end
endmodule

// File: rtl/cws_level_filter.sv
module cws_level_filter #(
    parameter int unsigned HOLD_TICKS = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic active,
    input  logic lvl,
    input  logic cur,
    output logic accept
);
    localparam int unsigned CW = $clog2(HOLD_TICKS + 1);

    logic [CW-1:0] cnt_q;
    logic          differs;

    assign differs = active && (lvl != cur);
    assign accept  = differs && tick && (cnt_q == CW'(HOLD_TICKS - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!differs || accept) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end
endmodule

// File: rtl/cws_cycle_seq.sv
module cws_cycle_seq
    import cws_pkg::*;
#(
    parameter int unsigned N           = 4,
    parameter int unsigned PCNT_W      = 22,
    parameter int unsigned T1_STEP     = 500000,
    parameter int unsigned T2_PERIOD   = 50000,
    parameter int unsigned ON_T1_SHORT = 10000,
    parameter int unsigned ON_T1_LONG  = 20000,
    parameter int unsigned ON_T2_SHORT = 100,
    parameter int unsigned ON_T2_LONG  = 1000,
    parameter int unsigned DLY_SHORT   = 80,
    parameter int unsigned DLY_LONG    = 800,
    parameter int unsigned FILT        = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         cyc_mode,
    input  logic         timer_sel,
    input  logic [2:0]   period_code,
    input  logic         on_long,
    input  logic         delay_long,
    input  logic [N-1:0] in_lvl,
    output logic         supply_on,
    output logic         eval,
    output logic         first_eval,
    output logic [N-1:0] samp_lvl,
    output logic [N-1:0] samp_ok
);
    cyc_state_t        state_q, state_d;
    logic [PCNT_W-1:0] pcnt_q, pcnt_d;
    logic [PCNT_W-1:0] period_t, on_t, dly_t, win_end;
    logic [N-1:0]      snap_q, unst_q;
    logic              ref_q;
    logic              snap_take, win_tick;

    // selected timing limits, all in ticks
    always_comb begin
        if (timer_sel) begin
            period_t = PCNT_W'(T2_PERIOD);
            on_t     = on_long ? PCNT_W'(ON_T2_LONG) : PCNT_W'(ON_T2_SHORT);
        end else begin
            period_t = PCNT_W'(T1_STEP) * PCNT_W'({1'b0, period_code} + 4'd1);
            on_t     = on_long ? PCNT_W'(ON_T1_LONG) : PCNT_W'(ON_T1_SHORT);
        end
        dly_t   = delay_long ? PCNT_W'(DLY_LONG) : PCNT_W'(DLY_SHORT);
        win_end = dly_t + PCNT_W'(FILT - 1);
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        pcnt_d  = pcnt_q;
        if (!cyc_mode) begin
            state_d = CS_IDLE;
            pcnt_d  = '0;
        end else begin
            unique case (state_q)
                CS_IDLE: begin
                    state_d = CS_SETTLE;
                    pcnt_d  = '0;
                end
                CS_SETTLE: if (tick) begin
                    pcnt_d = pcnt_q + PCNT_W'(1);
                    if (pcnt_q == dly_t - PCNT_W'(1)) state_d = CS_WINDOW;
                end
                CS_WINDOW: if (tick) begin
                    pcnt_d = pcnt_q + PCNT_W'(1);
                    if (pcnt_q == win_end) state_d = CS_HOLD;
                end
                CS_HOLD: if (tick) begin
                    pcnt_d = pcnt_q + PCNT_W'(1);
                    if (pcnt_q >= on_t - PCNT_W'(1)) state_d = CS_REST;
                end
                CS_REST: if (tick) begin
                    if (pcnt_q >= period_t - PCNT_W'(1)) begin
                        state_d = CS_SETTLE;
                        pcnt_d  = '0;
                    end else begin
                        pcnt_d = pcnt_q + PCNT_W'(1);
                    end
                end
                default: begin
                    state_d = CS_IDLE;
                    pcnt_d  = '0;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CS_IDLE;
            pcnt_q  <= '0;
        end else begin
            state_q <= state_d;
            pcnt_q  <= pcnt_d;
        end
    end

    assign snap_take = cyc_mode && (state_q == CS_SETTLE) && tick && (pcnt_q == dly_t - PCNT_W'(1));
    assign win_tick  = (state_q == CS_WINDOW) && tick;

    // sample snapshot, instability mask and reference marker
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            snap_q <= '0;
            unst_q <= '0;
            ref_q  <= 1'b0;
        end else begin
            if (snap_take) begin
                snap_q <= in_lvl;
                unst_q <= '0;
            end else if (win_tick) begin
                unst_q <= unst_q | (in_lvl ^ snap_q);
            end
            if (!cyc_mode)  ref_q <= 1'b0;
            else if (eval)  ref_q <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        supply_on  = (state_q == CS_SETTLE) || (state_q == CS_WINDOW) || (state_q == CS_HOLD);
        eval       = cyc_mode && win_tick && (pcnt_q == win_end);
        first_eval = !ref_q;
        samp_lvl   = snap_q;
        samp_ok    = ~(unst_q | (in_lvl ^ snap_q));
    end
endmodule

// File: rtl/cws_wake_sensor.sv
module cws_wake_sensor
    import cws_pkg::*;
#(
    parameter int unsigned N_IN              = 4,
    parameter int unsigned TICK_DIV          = 200,
    parameter int unsigned STATIC_FILT_TICKS = 64,
    parameter int unsigned CYC_FILT_TICKS    = 16,
    parameter int unsigned DLY_SHORT_TICKS   = 80,
    parameter int unsigned DLY_LONG_TICKS    = 800,
    parameter int unsigned T1_STEP_TICKS     = 500000,
    parameter int unsigned T2_PERIOD_TICKS   = 50000,
    parameter int unsigned ON_T1_SHORT       = 10000,
    parameter int unsigned ON_T1_LONG        = 20000,
    parameter int unsigned ON_T2_SHORT       = 100,
    parameter int unsigned ON_T2_LONG        = 1000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mode_cyclic,
    input  logic            timer_sel,
    input  logic [2:0]      period_code,
    input  logic            on_long,
    input  logic            delay_long,
    input  logic [N_IN-1:0] wake_en,
    input  logic [N_IN-1:0] wake_in,
    input  logic            wake_ack,
    output logic            supply_on,
    output logic [N_IN-1:0] in_status,
    output logic            wake_pulse,
    output logic            wake_flag
);
    localparam int unsigned PCNT_MAX = umax(8 * T1_STEP_TICKS, T2_PERIOD_TICKS);
    localparam int unsigned PCNT_W   = $clog2(PCNT_MAX + 1);

    logic            tick;
    logic            eval, first_eval;
    logic [N_IN-1:0] samp_lvl, samp_ok, accept;
    logic [N_IN-1:0] status_q, status_d, wake_set;
    logic            pulse_q, flag_q;

    cws_tick_gen #(.DIV(TICK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    for (genvar g = 0; g < N_IN; g++) begin : g_filt
        cws_level_filter #(.HOLD_TICKS(STATIC_FILT_TICKS)) u_filt (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick   (tick),
            .active (!mode_cyclic),
            .lvl    (wake_in[g]),
            .cur    (status_q[g]),
            .accept (accept[g])
        );
    end

    cws_cycle_seq #(
        .N           (N_IN),
        .PCNT_W      (PCNT_W),
        .T1_STEP     (T1_STEP_TICKS),
        .T2_PERIOD   (T2_PERIOD_TICKS),
        .ON_T1_SHORT (ON_T1_SHORT),
        .ON_T1_LONG  (ON_T1_LONG),
        .ON_T2_SHORT (ON_T2_SHORT),
        .ON_T2_LONG  (ON_T2_LONG),
        .DLY_SHORT   (DLY_SHORT_TICKS),
        .DLY_LONG    (DLY_LONG_TICKS),
        .FILT        (CYC_FILT_TICKS)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .cyc_mode    (mode_cyclic),
        .timer_sel   (timer_sel),
        .period_code (period_code),
        .on_long     (on_long),
        .delay_long  (delay_long),
        .in_lvl      (wake_in),
        .supply_on   (supply_on),
        .eval        (eval),
        .first_eval  (first_eval),
        .samp_lvl    (samp_lvl),
        .samp_ok     (samp_ok)
    );

    // status update and wake decision
    always_comb begin
        status_d = status_q;
        wake_set = '0;
        if (eval) begin
            for (int i = 0; i < N_IN; i++) begin
                if (samp_ok[i]) begin
                    status_d[i] = samp_lvl[i];
                    if (!first_eval && (samp_lvl[i] != status_q[i])) wake_set[i] = wake_en[i];
                end
            end
        end else begin
            for (int i = 0; i < N_IN; i++) begin
                if (accept[i]) begin
                    status_d[i] = wake_in[i];
                    wake_set[i] = wake_en[i];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= '0;
            pulse_q  <= 1'b0;
            flag_q   <= 1'b0;
        end else begin
            status_q <= status_d;
            pulse_q  <= |wake_set;
            flag_q   <= (|wake_set) || (flag_q && !wake_ack);
        end
    end

    assign in_status  = status_q;
    assign wake_pulse = pulse_q;
    assign wake_flag  = flag_q;
endmodule

// File: rtl/cws_wake_sensor_chk.sv
module cws_wake_sensor_chk #(
    parameter int unsigned N = 4
) (
    input logic         clk,
    input logic         rst_n,
    input logic         mode_cyclic,
    input logic [N-1:0] wake_en,
    input logic         wake_ack,
    input logic         supply_on,
    input logic [N-1:0] in_status,
    input logic         wake_pulse,
    input logic         wake_flag
);
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |-> (in_status == '0 && !supply_on && !wake_pulse && !wake_flag));

    a_r10_pulse_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |-> wake_flag);

    a_r10_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        wake_ack |=> (!wake_flag || wake_pulse));

    a_r11_static_supply_off: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_cyclic |=> !supply_on);

    a_r5_supply_needs_mode: assert property (@(posedge clk) disable iff (!rst_n)
        supply_on |-> $past(mode_cyclic));

    a_r6_cyclic_update_in_burst: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode_cyclic) && (in_status != $past(in_status))) |-> $past(supply_on));

    a_r7_wake_needs_change: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |-> (in_status != $past(in_status)));

    a_r4_wake_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |-> (((in_status ^ $past(in_status)) & $past(wake_en)) != '0));
endmodule

bind cws_wake_sensor cws_wake_sensor_chk #(.N(N_IN)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_cyclic (mode_cyclic),
    .wake_en     (wake_en),
    .wake_ack    (wake_ack),
    .supply_on   (supply_on),
    .in_status   (in_status),
    .wake_pulse  (wake_pulse),
    .wake_flag   (wake_flag)
);

// File: tb/sim_cws_wake_sensor.sv
`timescale 1ns/1ps
module sim_cws_wake_sensor;
    localparam int SF   = 8;
    localparam int CF   = 4;
    localparam int T1S  = 60;
    localparam int T2P  = 50;
    localparam int ON1S = 20;
    localparam int ON1L = 30;
    localparam int ON2S = 15;
    localparam int ON2L = 25;
    localparam int DS   = 3;
    localparam int DL   = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_cyclic = 1'b0, timer_sel = 1'b0, on_long = 1'b0, delay_long = 1'b0;
    logic [2:0] period_code = 3'd0;
    logic [3:0] wake_en = 4'hF, wake_in = 4'h0;
    logic       wake_ack = 1'b0;
    logic       supply_on, wake_pulse, wake_flag;
    logic [3:0] in_status;

    int n_cmp = 0, n_bad = 0, pcount = 0;
    logic [3:0] st;

    always #2.5 clk = ~clk;

    cws_wake_sensor #(
        .N_IN(4), .TICK_DIV(1), .STATIC_FILT_TICKS(SF), .CYC_FILT_TICKS(CF),
        .DLY_SHORT_TICKS(DS), .DLY_LONG_TICKS(DL), .T1_STEP_TICKS(T1S),
        .T2_PERIOD_TICKS(T2P), .ON_T1_SHORT(ON1S), .ON_T1_LONG(ON1L),
        .ON_T2_SHORT(ON2S), .ON_T2_LONG(ON2L)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .mode_cyclic(mode_cyclic), .timer_sel(timer_sel),
        .period_code(period_code), .on_long(on_long), .delay_long(delay_long),
        .wake_en(wake_en), .wake_in(wake_in), .wake_ack(wake_ack),
        .supply_on(supply_on), .in_status(in_status), .wake_pulse(wake_pulse),
        .wake_flag(wake_flag)
    );

    always @(posedge clk) if (wake_pulse === 1'b1) pcount++;

    function automatic int f_period(bit ts, int code);
        return ts ? T2P : (code + 1) * T1S;
    endfunction
    function automatic int f_on(bit ts, bit ol);
        return ts ? (ol ? ON2L : ON2S) : (ol ? ON1L : ON1S);
    endfunction
    function automatic int f_dly(bit dl);
        return dl ? DL : DS;
    endfunction
    function automatic int f_wake(logic [3:0] prev, logic [3:0] nxt, logic [3:0] en, bit first);
        return (!first && (((prev ^ nxt) & en) != 4'h0)) ? 1 : 0;
    endfunction

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wait_rise();
        while (supply_on === 1'b1) step(1);
        while (supply_on !== 1'b1) step(1);
    endtask

    task automatic sync_eval();
        wait_rise();
        step(f_dly(delay_long) + CF);
    endtask

    task automatic measure(output int on_c, output int per_c);
        int off_c;
        wait_rise();
        on_c = 0;
        off_c = 0;
        while (supply_on === 1'b1) begin on_c++; step(1); end
        while (supply_on !== 1'b1) begin off_c++; step(1); end
        per_c = on_c + off_c;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int p0, on_c, per_c;
        logic [3:0] v, e, x;
        void'($urandom(32'd1234));

        // R1 reset
        step(3);
        chk("R1 status in reset", int'(in_status), 0);
        chk("R1 supply in reset", int'(supply_on), 0);
        chk("R1 flag in reset", int'(wake_flag), 0);
        rst_n = 1'b1;
        step(2);
        chk("R1 status after reset", int'(in_status), 0);
        chk("R1 pulse after reset", int'(wake_pulse), 0);

        // R2/R3 static rising acceptance
        wake_in = 4'b0001;
        step(SF - 1);
        chk("R2 status before filter end", int'(in_status), 0);
        step(1);
        chk("R2 status at filter end", int'(in_status), 1);
        chk("R3 rising wake", int'(wake_pulse), 1);
        chk("R10 flag set with pulse", int'(wake_flag), 1);
        step(1);
        chk("R10 pulse one cycle", int'(wake_pulse), 0);

        // R2 glitch shorter than filter
        p0 = pcount;
        wake_in = 4'b0011;
        step(SF - 1);
        wake_in = 4'b0001;
        step(SF + 2);
        chk("R2 glitch status", int'(in_status), 1);
        chk("R2 glitch no wake", pcount - p0, 0);

        // R3 falling
        wake_in = 4'b0000;
        step(SF);
        chk("R3 falling status", int'(in_status), 0);
        chk("R3 falling wake", int'(wake_pulse), 1);
        step(1);

        // R4 disabled input, R11 supply off in static
        wake_en = 4'b1011;
        p0 = pcount;
        wake_in = 4'b0100;
        step(SF + 2);
        chk("R4 disabled status follows", int'(in_status), 4);
        chk("R4 disabled no wake", pcount - p0, 0);
        chk("R11 static supply", int'(supply_on), 0);

        // R10 acknowledge and collision
        wake_ack = 1'b1;
        step(1);
        wake_ack = 1'b0;
        chk("R10 ack clears", int'(wake_flag), 0);
        wake_in = 4'b0110;
        step(SF - 1);
        wake_ack = 1'b1;
        step(1);
        wake_ack = 1'b0;
        chk("R10 set beats ack flag", int'(wake_flag), 1);
        chk("R10 set beats ack pulse", int'(wake_pulse), 1);
        step(1);
        chk("R10 flag sticky", int'(wake_flag), 1);
        wake_ack = 1'b1;
        step(1);
        wake_ack = 1'b0;
        chk("R10 lone ack", int'(wake_flag), 0);
        st = 4'b0110;
        wake_en = 4'hF;

        // random static rounds
        for (int k = 0; k < 6; k++) begin
            v = 4'($urandom % 16);
            e = 4'($urandom % 16);
            wake_en = e;
            wake_in = v;
            step(SF);
            chk("R2 random static status", int'(in_status), int'(v));
            chk("R4 random static wake", int'(wake_pulse), f_wake(st, v, e, 1'b0));
            st = v;
            step(2);
        end
        wake_en = 4'hF;

        // R5 supply timing for several settings
        for (int k = 0; k < 5; k++) begin
            bit ts, ol;
            int code;
            case (k)
                0: begin ts = 1; code = 0; ol = 0; end
                1: begin ts = 1; code = 5; ol = 1; end
                2: begin ts = 0; code = 0; ol = 0; end
                3: begin ts = 0; code = 3; ol = 1; end
                default: begin ts = 0; code = 7; ol = 0; end
            endcase
            mode_cyclic = 1'b0;
            timer_sel = ts;
            period_code = 3'(code);
            on_long = ol;
            delay_long = k[0];
            step(2);
            chk("R11 supply off in static", int'(supply_on), 0);
            mode_cyclic = 1'b1;
            measure(on_c, per_c);
            chk("R5 on-time", on_c, f_on(ts, ol));
            chk("R5 period", per_c, f_period(ts, code));
        end
        mode_cyclic = 1'b0;
        timer_sel = 1'b1;
        on_long = 1'b1;
        delay_long = 1'b1;
        step(2);

        // R9 first sample is reference
        x = ~st;
        wake_in = x;
        mode_cyclic = 1'b1;
        p0 = pcount;
        sync_eval();
        chk("R9 first sample stored", int'(in_status), int'(x));
        chk("R9 first sample no wake", int'(wake_pulse), 0);
        st = x;

        // R6 change after window waits for next period
        v = st ^ 4'b0011;
        wake_in = v;
        step(3);
        chk("R6 status held between samples", int'(in_status), int'(st));
        sync_eval();
        chk("R6 status at next sample", int'(in_status), int'(v));
        chk("R7 change wakes", int'(wake_pulse), 1);
        st = v;

        // R7 no change
        sync_eval();
        chk("R7 same sample status", int'(in_status), int'(st));
        chk("R7 same sample no wake", int'(wake_pulse), 0);

        // R8 unstable inside window
        wait_rise();
        step(f_dly(delay_long) + 1);
        v = st ^ 4'b1000;
        wake_in = v;
        step(CF - 1);
        chk("R8 unstable keeps status", int'(in_status), int'(st));
        chk("R8 unstable no wake", int'(wake_pulse), 0);
        sync_eval();
        chk("R8 stable next period status", int'(in_status), int'(v));
        chk("R8 stable next period wake", int'(wake_pulse), 1);
        st = v;

        // R4 disabled in cyclic
        wake_en = 4'b1110;
        v = st ^ 4'b0001;
        wake_in = v;
        sync_eval();
        chk("R4 cyclic disabled status", int'(in_status), int'(v));
        chk("R4 cyclic disabled no wake", int'(wake_pulse), 0);
        st = v;

        // random cyclic rounds
        for (int k = 0; k < 10; k++) begin
            v = 4'($urandom % 16);
            e = 4'($urandom % 16);
            wake_en = e;
            wake_in = v;
            sync_eval();
            chk("R7 random cyclic status", int'(in_status), int'(v));
            chk("R7 random cyclic wake", int'(wake_pulse), f_wake(st, v, e, 1'b0));
            st = v;
        end

        mode_cyclic = 1'b0;
        step(2);
        chk("R11 supply off after leaving cyclic", int'(supply_on), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule